// File: doc/BRIEF.md
# Fractional Pulse-Swallow Divider Controller

This block holds the programmable counters that sit behind a dual-modulus 16/17 prescaler in a fractional-N synthesizer loop. Its clock is the prescaler output, so one clock is one prescaler cycle of 16 or 17 oscillator periods. At the start of every division it adds the signed 3-bit noise-shaper sample to the programmed integer ratio. It splits the sum into a main count P, the upper bits, and a swallow count S, the low four bits. It then holds the modulus-control line high for the first S prescaler cycles of the division and low for the rest. The division therefore lasts 16·P + S oscillator periods.

Because the effective ratio is rebuilt and reloaded at every terminal count, a plain dual-modulus prescaler can follow a multi-level modulator stream. Without this, a multi-modulus prescaler would be needed. The divided pulse goes to the phase detector, which in normal use runs at about 13 MHz. An error flag marks any division whose ratio cannot be produced exactly.

Top module: `fnd_frac_divider`

## Requirements
- R1: While reset is low, `mod_ctrl`, `div_pulse` and `ratio_err` are all low. The first prescaler clock edge after reset is released loads a new division.
- R2: The ratio of a division is `ndiv` plus `mod_word`, read as two's complement (range -4 to +3). P is the ratio shifted right by four, S is its low four bits, and the division lasts 16·P + S oscillator periods when S ≤ P and P ≥ 1.
- R3: `mod_ctrl` (1 = divide by 17, 0 = divide by 16) is driven high on the load edge when S is nonzero and stays high for exactly S consecutive prescaler cycles. It is low for the remaining P − S cycles.
- R4: `ndiv` and `mod_word` are sampled only on the load edge. A change of either input during a division leaves that division's length unchanged and takes effect at the next load.
- R5: `div_pulse` rises one prescaler cycle after each load edge and stays high for one prescaler cycle (16 or 17 oscillator periods) when P ≥ 2. Successive rising edges are therefore one whole division apart.
- R6: `ratio_err` is updated on each load edge and then held for the whole division. It goes high when the sum is negative, when P is 0, or when S > P. It is low otherwise, including at S = P.
- R7: An out-of-range ratio still gives a defined division. A negative sum is clamped to zero. The division lasts max(P,1) prescaler cycles, and of those min(S, max(P,1)) use divide-by-17. With a zero ratio, every prescaler cycle is a division, `div_pulse` stays high and `mod_ctrl` stays low.
- R8: Each division uses its own modulator sample, so a different `mod_word` in each of a run of divisions gives each division its own length. All eight values from -4 to +3 apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock; one edge per prescaler cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ndiv | input | NDIV_W (10) | Integer divide ratio in oscillator periods |
| mod_word | input | 3 | Signed modulator sample, -4 to +3 |
| mod_ctrl | output | 1 | Prescaler modulus select, 1 = divide by 17 |
| div_pulse | output | 1 | Divided output to the phase detector |
| ratio_err | output | 1 | Current division's ratio is out of range |

## Verification
The ratio and error flag are set on the load edge. The modulus line is set on that edge too, but the prescaler model in the bench only applies it to the prescaler cycle that follows. For the same reason, `div_pulse` is retimed so that it rises one prescaler cycle after the load, and a period measured between two rising edges spans exactly one division. The bench samples every output on the oscillator's falling edge. It compares the error flag at each pulse rise with the division that has just begun. It compares the oscillator count since the previous rise with the division that has just ended. New inputs are applied half a prescaler cycle after a pulse rise, well inside the division already loaded, so every item also checks that a mid-division change has no effect. The final zero-ratio phase is checked after several prescaler cycles, once the continuous reload has settled.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

  // log2 of the prescaler's base modulus (16); the swallow field width
  localparam int unsigned PRE_LOG = 4;

  // width of the signed modulator sample
  localparam int unsigned MOD_W = 3;

  // prescaler modulus selection held by the swallow counter
  typedef enum logic {
    MODULUS_BASE  = 1'b0,
    MODULUS_PLUS1 = 1'b1
  } modulus_e;

endpackage

// File: rtl/fnd_ratio_split.sv
module fnd_ratio_split
  import fnd_pkg::*;
#(
  parameter int unsigned NDIV_W = 10
) (
  input  logic [NDIV_W-1:0]        ndiv,
  input  logic [MOD_W-1:0]         mod_word,
  output logic [NDIV_W-PRE_LOG:0]  main_load,
  output logic [PRE_LOG-1:0]       swal_load,
  output logic                     ratio_bad
);

  localparam int unsigned SUM_W  = NDIV_W + 2;
  localparam int unsigned MAIN_W = NDIV_W + 1 - PRE_LOG;
  localparam int unsigned PAD_W  = MAIN_W - PRE_LOG;

  logic signed [SUM_W-1:0] sum_s;
  logic [NDIV_W:0]         sum_u;
  logic                    sum_neg;
  logic [MAIN_W-1:0]       swal_ext;

  // integer ratio plus sign-extended modulator sample, clamped at zero
  always_comb begin
    sum_s = $signed({2'b00, ndiv})
          + $signed({{(SUM_W-MOD_W){mod_word[MOD_W-1]}}, mod_word});
    sum_neg   = sum_s[SUM_W-1];
    sum_u     = sum_neg ? '0 : sum_s[NDIV_W:0];
    main_load = sum_u[NDIV_W:PRE_LOG];
    swal_load = sum_u[PRE_LOG-1:0];
    swal_ext  = {{PAD_W{1'b0}}, swal_load};
    ratio_bad = sum_neg | (main_load == '0) | (swal_ext > main_load);
  end

endmodule

// File: rtl/fnd_main_counter.sv
module fnd_main_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             term,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // counts prescaler cycles left in the division after the current one
  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = (load_val == '0) ? '0 : load_val - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign term = (cnt_q == '0);
  assign cnt  = cnt_q;

endmodule

// File: rtl/fnd_swallow_counter.sv
module fnd_swallow_counter
  import fnd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PRE_LOG-1:0] load_val,
  output modulus_e           modulus,
  output logic [PRE_LOG-1:0] remain
);

  logic [PRE_LOG-1:0] swal_q;
  logic [PRE_LOG-1:0] swal_d;
  modulus_e           mod_q;
  modulus_e           mod_d;
  logic               swal_en;

  // the plus-one modulus is issued once per remaining swallow count
  always_comb begin
    swal_en = load | (swal_q != '0) | (mod_q == MODULUS_PLUS1);
    if (load) begin
      mod_d  = (load_val != '0) ? MODULUS_PLUS1 : MODULUS_BASE;
      swal_d = (load_val != '0) ? load_val - PRE_LOG'(1) : '0;
    end else begin
      mod_d  = (swal_q != '0) ? MODULUS_PLUS1 : MODULUS_BASE;
      swal_d = (swal_q != '0) ? swal_q - PRE_LOG'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swal_q <= '0;
      mod_q  <= MODULUS_BASE;
    end else if (swal_en) begin
      swal_q <= swal_d;
      mod_q  <= mod_d;
    end
  end

  assign modulus = mod_q;
  assign remain  = swal_q;

  // a run of divide-by-17 cycles may only begin on a load edge
  assert_plus1_starts_on_load_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
      $rose(mod_q == MODULUS_PLUS1) |-> $past(load)
  );

endmodule

// File: rtl/fnd_frac_divider.sv
module fnd_frac_divider
  import fnd_pkg::*;
#(
  parameter int unsigned NDIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDIV_W-1:0] ndiv,
  input  logic [MOD_W-1:0]  mod_word,
  output logic              mod_ctrl,
  output logic              div_pulse,
  output logic              ratio_err
);

  localparam int unsigned MAIN_W = NDIV_W + 1 - PRE_LOG;

  logic [MAIN_W-1:0]  main_load;
  logic [MAIN_W-1:0]  main_cnt;
  logic [PRE_LOG-1:0] swal_load;
  logic [PRE_LOG-1:0] swal_cnt;
  logic               ratio_bad;
  logic               load;
  modulus_e           modulus;

  logic err_q, err_d;
  logic tc_q, tc_d;
  logic pulse_q, pulse_d;

  fnd_ratio_split #(.NDIV_W(NDIV_W)) u_split (
    .ndiv      (ndiv),
    .mod_word  (mod_word),
    .main_load (main_load),
    .swal_load (swal_load),
    .ratio_bad (ratio_bad)
  );

  fnd_main_counter #(.CNT_W(MAIN_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (main_load),
    .term     (load),
    .cnt      (main_cnt)
  );

  fnd_swallow_counter u_swal (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (swal_load),
    .modulus  (modulus),
    .remain   (swal_cnt)
  );

  // error captured per division; pulse retimed one prescaler cycle so it
  // lines up with the modulus the prescaler applies one cycle late
  always_comb begin
    err_d   = load ? ratio_bad : err_q;
    tc_d    = load;
    pulse_d = tc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      tc_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (load) begin
        err_q <= err_d;
      end
      tc_q    <= tc_d;
      pulse_q <= pulse_d;
    end
  end

  assign mod_ctrl  = (modulus == MODULUS_PLUS1);
  assign div_pulse = pulse_q;
  assign ratio_err = err_q;

  assert_err_held_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
      !load |=> $stable(ratio_err)
  );

  assert_pulse_follows_tc_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
      $rose(div_pulse) |-> $past(load, 2)
  );

  assert_swallow_within_main_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
      (!ratio_err && swal_cnt != '0) |-> (MAIN_W'(swal_cnt) <= main_cnt)
  );

endmodule

// File: tb/fnd_frac_divider_bench.sv
module fnd_frac_divider_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 2;
  localparam int NDIV_W     = 10;

  logic              vco_clk = 1'b0;
  logic              pre_clk = 1'b0;
  logic [4:0]        pcnt    = 5'd0;
  logic [4:0]        plen    = 5'd16;
  logic              rst_n;
  logic [NDIV_W-1:0] ndiv;
  logic [2:0]        mod_word;
  logic              mod_ctrl;
  logic              div_pulse;
  logic              ratio_err;

  int checks = 0;
  int fails  = 0;
  int per_q[$];
  int err_q[$];
  int pulse_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) vco_clk = ~vco_clk;

  // dual-modulus prescaler model: picks next length from mod_ctrl at cycle end
  always @(posedge vco_clk) begin
    if (pcnt == plen - 5'd1) begin
      pcnt    <= 5'd0;
      plen    <= mod_ctrl ? 5'd17 : 5'd16;
      pre_clk <= 1'b1;
    end else begin
      pcnt <= pcnt + 5'd1;
      if (pcnt == 5'd7) pre_clk <= 1'b0;
    end
  end

  fnd_frac_divider #(.NDIV_W(NDIV_W)) u_fnd_frac_divider (
    .clk       (pre_clk),
    .rst_n     (rst_n),
    .ndiv      (ndiv),
    .mod_word  (mod_word),
    .mod_ctrl  (mod_ctrl),
    .div_pulse (div_pulse),
    .ratio_err (ratio_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int nd, input int md);
    int sum, p, s, pe, se;
    sum = nd + md;
    if (sum < 0) sum = 0;
    p  = sum / 16;
    s  = sum % 16;
    pe = (p < 1) ? 1 : p;
    se = (s < pe) ? s : pe;
    return 16 * pe + se;
  endfunction

  function automatic int exp_err(input int nd, input int md);
    int sum, p, s;
    sum = nd + md;
    if (sum < 0) return 1;
    p = sum / 16;
    s = sum % 16;
    return ((p == 0) || (s > p)) ? 1 : 0;
  endfunction

  // driver: set inputs and push what the division they load must produce
  task automatic apply(input int nd, input int md);
    ndiv     = NDIV_W'(nd);
    mod_word = 3'(md);
    per_q.push_back(exp_period(nd, md));
    err_q.push_back(exp_err(nd, md));
  endtask

  task automatic next_slot();
    int c;
    c = pulse_cnt;
    wait (pulse_cnt != c);
    @(negedge pre_clk);
  endtask

  // monitor: period and pulse width in oscillator cycles, error at each rise
  int  vcnt = 0;
  int  wcnt = 0;
  bit  have_prev = 1'b0;
  logic pulse_prev = 1'b0;

  always @(negedge vco_clk) begin
    if (rst_n === 1'b1) begin
      vcnt++;
      wcnt++;
      if (div_pulse && !pulse_prev) begin
        pulse_cnt++;
        if (have_prev) begin
          if (per_q.size() == 0) check(1'b0, "R2 period queue empty", vcnt, -1);
          else begin
            int e;
            e = per_q.pop_front();
            check(vcnt == e, "R2/R3/R4/R7/R8 division period", vcnt, e);
          end
        end
        if (err_q.size() == 0) check(1'b0, "R6 error queue empty", ratio_err, -1);
        else begin
          int e;
          e = err_q.pop_front();
          check(int'(ratio_err) == e, "R6 ratio_err at division start", ratio_err, e);
        end
        have_prev = 1'b1;
        vcnt = 0;
        wcnt = 0;
      end else if (!div_pulse && pulse_prev) begin
        check(wcnt == 16 || wcnt == 17, "R5 pulse width", wcnt, 16);
      end
      pulse_prev = div_pulse;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(200, 0);
    repeat (3) @(negedge pre_clk);
    check(mod_ctrl == 1'b0,  "R1 mod_ctrl in reset",  mod_ctrl, 0);
    check(div_pulse == 1'b0, "R1 div_pulse in reset", div_pulse, 0);
    check(ratio_err == 1'b0, "R1 ratio_err in reset", ratio_err, 0);
    @(negedge pre_clk);
    rst_n = 1'b1;
    // R8 / R2: every modulator value in turn
    for (int m = -4; m <= 3; m++) begin
      next_slot();
      apply(300, m);
    end
    next_slot(); apply(256, 0);    // R3 zero swallow count
    next_slot(); apply(255, 0);    // R3 S=15 with P=15
    next_slot(); apply(600, 3);    // R4 large change during a running division
    next_slot(); apply(47, 0);     // R6/R7 S>P: 17*2
    next_slot(); apply(33, -1);    // R2 P=2 S=0
    next_slot(); apply(50, -4);    // R6/R7 S=14>P=2
    next_slot(); apply(1023, 3);   // R2 top of range
    next_slot(); apply(37, -3);    // R6 S==P is valid
    next_slot(); apply(150, -2);
    next_slot(); apply(3, -4);     // R7 negative sum clamps to zero
    next_slot();
    repeat (6) @(negedge pre_clk);
    check(div_pulse == 1'b1, "R7 pulse held at zero ratio",    div_pulse, 1);
    check(ratio_err == 1'b1, "R7 error at negative sum",       ratio_err, 1);
    check(mod_ctrl == 1'b0,  "R7 modulus 16 at zero ratio",    mod_ctrl, 0);
    check(err_q.size() == 0, "R5 one pulse for every division", err_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge vco_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", pulse_cnt, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule